// File: doc/BRIEF.md
# Bridge Packet Claim and Error Log Steering

This block sits in the transaction layer of a switch port whose bridge function shares the port with other functions. For every decoded packet header it decides whether the bridge function takes ownership of the packet. The decision depends on the packet's routing kind, on the side of the bridge the packet arrived from, and on the bridge's programmed address windows, bus numbers and identity.

The same strobe also carries two error flags raised elsewhere for that packet. An error that concerns the whole port opens the error log of every function. An error tied to a function opens only the log of the function that owns the packet. Ownership by the other functions of the port comes in from their own claim logic. Both results are registered and held until the next header.

Top module: `bridge_claim_steer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `claim`, `log_en` and `unclaimed` are all zero.
- R2: `claim`, `log_en` and `unclaimed` update on the clock edge that samples `hdr_vld` high. So they are visible one cycle after the strobe. `claim` and `log_en` keep their value while `hdr_vld` is low.
- R3: Packets routed by address (`route` = 2'b00) that arrive on the primary side (`from_sec` = 0) are claimed when the address lies inside at least one of three windows, with both bounds included. The windows are: the 32-bit I/O window, the 32-bit memory window and the 64-bit prefetchable window. A 32-bit window matches only addresses whose upper 32 bits are zero.
- R4: A window whose limit is below its base matches no address.
- R5: Packets routed by ID (`route` = 2'b01) that arrive on the primary side are claimed when the destination bus lies between `sec_bus` and `sub_bus` inclusive. They are also claimed when bus, device and function all equal the bridge's own identity.
- R6: Packets routed by address or by ID that arrive on the secondary side (`from_sec` = 1) are always claimed.
- R7: Packets with implicit routing (`route` = 2'b10) are always claimed on either side. The reserved code 2'b11 is never claimed.
- R8: A port-wide error (`err_port` = 1) sets every bit of `log_en`, whatever the claim result.
- R9: A function-specific error (`err_fn` = 1, `err_port` = 0) sets only the `log_en` bits of the functions that claimed the packet. Bit `BRIDGE_IDX` is the bridge's own claim. The other bits take `peer_claim` in ascending order, skipping `BRIDGE_IDX`. With no error flag, `log_en` is zero.
- R10: A function-specific error (without a port-wide error) on a packet that no function claimed leaves `log_en` zero and raises `unclaimed` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_vld | input | 1 | Header strobe |
| route | input | 2 | Routing kind: 00 address, 01 ID, 10 implicit, 11 reserved |
| from_sec | input | 1 | 1 when the packet arrived on the secondary side |
| addr | input | ADDR_W (64) | Packet address |
| dst_bus | input | BUS_W (8) | Destination bus |
| dst_dev | input | DEV_W (5) | Destination device |
| dst_fn | input | FN_W (3) | Destination function |
| err_port | input | 1 | Port-wide error raised with this packet |
| err_fn | input | 1 | Function-specific error raised with this packet |
| peer_claim | input | NUM_FN-1 | Claims of the other functions of the port |
| io_base | input | 32 | I/O window base |
| io_limit | input | 32 | I/O window limit |
| mem_base | input | 32 | Memory window base |
| mem_limit | input | 32 | Memory window limit |
| pf_base | input | ADDR_W | Prefetchable window base |
| pf_limit | input | ADDR_W | Prefetchable window limit |
| sec_bus | input | BUS_W | Secondary bus number |
| sub_bus | input | BUS_W | Subordinate bus number |
| own_bus | input | BUS_W | Bridge's own bus |
| own_dev | input | DEV_W | Bridge's own device |
| own_fn | input | FN_W | Bridge's own function |
| claim | output | 1 | Bridge claims the packet |
| log_en | output | NUM_FN | Per-function error log enable |
| unclaimed | output | 1 | One-cycle pulse: function error on an unclaimed packet |

## Verification
Directed headers place the address exactly on each window's base and limit and one step outside each. This separates inclusive from exclusive comparison. A reversed window and a 32-bit window hit by a 64-bit address show whether disabled and narrow windows wrongly match. Destination buses at the secondary number, the subordinate number and one past it, plus an exact own-identity hit, separate the aperture test from the identity test. Random headers over both sides, all four routing codes and all error-flag combinations, checked against a bench model, expose any mix-up between port-wide and per-function steering and any missing unclaimed pulse.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    RT_ADDR = 2'b00,
    RT_ID   = 2'b01,
    RT_IMPL = 2'b10,
    RT_RSVD = 2'b11
  } route_e;

  localparam int unsigned NUM_WIN = 3;
endpackage

// File: rtl/bcs_win_match.sv
module bcs_win_match #(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  logic enabled;
  assign enabled = (hi >= lo);
  assign hit     = enabled && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bcs_id_match.sv
module bcs_id_match #(
  parameter int unsigned BW = 8,
  parameter int unsigned DW = 5,
  parameter int unsigned FW = 3
) (
  input  logic [BW-1:0] bus,
  input  logic [DW-1:0] dev,
  input  logic [FW-1:0] fn,
  input  logic [BW-1:0] sec_bus,
  input  logic [BW-1:0] sub_bus,
  input  logic [BW-1:0] own_bus,
  input  logic [DW-1:0] own_dev,
  input  logic [FW-1:0] own_fn,
  output logic          hit
);
  logic in_range;
  logic is_self;
  assign in_range = (bus >= sec_bus) && (bus <= sub_bus);
  assign is_self  = (bus == own_bus) && (dev == own_dev) && (fn == own_fn);
  assign hit      = in_range || is_self;
endmodule

// File: rtl/bcs_steer.sv
module bcs_steer #(
  parameter int unsigned NF  = 4,
  parameter int unsigned IDX = 0
) (
  input  logic          own_claim,
  input  logic [NF-2:0] peer_claim,
  input  logic          err_port,
  input  logic          err_fn,
  output logic [NF-1:0] log_vec,
  output logic          orphan
);
  logic [NF-1:0] owners;

  for (genvar i = 0; i < NF; i++) begin : g_own
    if (i == IDX) begin : g_self
      assign owners[i] = own_claim;
    end else if (i < IDX) begin : g_lo
      assign owners[i] = peer_claim[i];
    end else begin : g_hi
      assign owners[i] = peer_claim[i-1];
    end
  end

  always_comb begin
    if (err_port)    log_vec = '1;
    else if (err_fn) log_vec = owners;
    else             log_vec = '0;
  end

  assign orphan = err_fn && !err_port && (owners == '0);
endmodule

// File: rtl/bridge_claim_steer.sv
module bridge_claim_steer
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned BUS_W      = 8,
  parameter int unsigned DEV_W      = 5,
  parameter int unsigned FN_W       = 3,
  parameter int unsigned NUM_FN     = 4,
  parameter int unsigned BRIDGE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_vld,
  input  logic [1:0]        route,
  input  logic              from_sec,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  dst_bus,
  input  logic [DEV_W-1:0]  dst_dev,
  input  logic [FN_W-1:0]   dst_fn,
  input  logic              err_port,
  input  logic              err_fn,
  input  logic [NUM_FN-2:0] peer_claim,
  input  logic [31:0]       io_base,
  input  logic [31:0]       io_limit,
  input  logic [31:0]       mem_base,
  input  logic [31:0]       mem_limit,
  input  logic [ADDR_W-1:0] pf_base,
  input  logic [ADDR_W-1:0] pf_limit,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  input  logic [BUS_W-1:0]  own_bus,
  input  logic [DEV_W-1:0]  own_dev,
  input  logic [FN_W-1:0]   own_fn,
  output logic              claim,
  output logic [NUM_FN-1:0] log_en,
  output logic              unclaimed
);
  localparam int unsigned PAD_W = ADDR_W - 32;

  logic [ADDR_W-1:0]  win_lo [NUM_WIN];
  logic [ADDR_W-1:0]  win_hi [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic               id_hit;
  logic               claim_d;
  logic [NUM_FN-1:0]  log_d;
  logic               orphan_d;
  route_e             rt;

  assign rt = route_e'(route);

  // 32-bit windows are zero-extended, so any address with upper bits set misses them
  assign win_lo[0] = {{PAD_W{1'b0}}, io_base};
  assign win_hi[0] = {{PAD_W{1'b0}}, io_limit};
  assign win_lo[1] = {{PAD_W{1'b0}}, mem_base};
  assign win_hi[1] = {{PAD_W{1'b0}}, mem_limit};
  assign win_lo[2] = pf_base;
  assign win_hi[2] = pf_limit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bcs_win_match #(.AW(ADDR_W)) u_win (
      .addr (addr),
      .lo   (win_lo[w]),
      .hi   (win_hi[w]),
      .hit  (win_hit[w])
    );
  end

  bcs_id_match #(.BW(BUS_W), .DW(DEV_W), .FW(FN_W)) u_id (
    .bus     (dst_bus),
    .dev     (dst_dev),
    .fn      (dst_fn),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .own_bus (own_bus),
    .own_dev (own_dev),
    .own_fn  (own_fn),
    .hit     (id_hit)
  );

  always_comb begin
    unique case (rt)
      RT_ADDR: claim_d = from_sec || (|win_hit);
      RT_ID:   claim_d = from_sec || id_hit;
      RT_IMPL: claim_d = 1'b1;
      default: claim_d = 1'b0;
    endcase
  end

  bcs_steer #(.NF(NUM_FN), .IDX(BRIDGE_IDX)) u_steer (
    .own_claim  (claim_d),
    .peer_claim (peer_claim),
    .err_port   (err_port),
    .err_fn     (err_fn),
    .log_vec    (log_d),
    .orphan     (orphan_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      claim     <= 1'b0;
      log_en    <= '0;
      unclaimed <= 1'b0;
    end else if (hdr_vld) begin
      claim     <= claim_d;
      log_en    <= log_d;
      unclaimed <= orphan_d;
    end else begin
      unclaimed <= 1'b0;
    end
  end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int unsigned NUM_FN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_vld,
  input logic [1:0]        route,
  input logic              from_sec,
  input logic              err_port,
  input logic              err_fn,
  input logic              claim,
  input logic [NUM_FN-1:0] log_en,
  input logic              unclaimed
);
  // R2: outputs hold without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !hdr_vld |=> ($stable(claim) && $stable(log_en)));

  // R10: the unclaimed pulse lasts one cycle
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    !hdr_vld |=> !unclaimed);

  // R10: the unclaimed pulse comes with no log enable
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    unclaimed |-> (log_en == '0));

  // R8: a port-wide error opens every log
  a_r8_all: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && err_port) |=> (&log_en));

  // R7: implicit routing is always claimed, reserved never
  a_r7_impl: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && route == 2'b10) |=> claim);
  a_r7_rsvd: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && route == 2'b11) |=> !claim);

  // R6: secondary side claims address and ID routed packets
  a_r6_sec: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && from_sec && !route[1]) |=> claim);

  // R9: no error flag leaves every log closed
  a_r9_none: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && !err_port && !err_fn) |=> (log_en == '0));
endmodule

bind bridge_claim_steer bcs_checker #(.NUM_FN(NUM_FN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hdr_vld   (hdr_vld),
  .route     (route),
  .from_sec  (from_sec),
  .err_port  (err_port),
  .err_fn    (err_fn),
  .claim     (claim),
  .log_en    (log_en),
  .unclaimed (unclaimed)
);

// File: tb/sim_bridge_claim_steer.sv
module sim_bridge_claim_steer;
  localparam int NF  = 4;
  localparam int BIX = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_vld = 1'b0;
  logic [1:0]  route = 2'b00;
  logic        from_sec = 1'b0;
  logic [63:0] addr = '0;
  logic [7:0]  dst_bus = '0;
  logic [4:0]  dst_dev = '0;
  logic [2:0]  dst_fn = '0;
  logic        err_port = 1'b0;
  logic        err_fn = 1'b0;
  logic [NF-2:0] peer_claim = '0;
  logic [31:0] io_base = 32'h0000_1000, io_limit = 32'h0000_1FFF;
  logic [31:0] mem_base = 32'h8000_0000, mem_limit = 32'h80FF_FFFF;
  logic [63:0] pf_base = 64'h0000_0004_0000_0000, pf_limit = 64'h0000_0004_FFFF_FFFF;
  logic [7:0]  sec_bus = 8'd5, sub_bus = 8'd9, own_bus = 8'd2;
  logic [4:0]  own_dev = 5'd3;
  logic [2:0]  own_fn = 3'd0;
  logic        claim;
  logic [NF-1:0] log_en;
  logic        unclaimed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bridge_claim_steer u0 (
    .clk(clk), .rst(rst), .hdr_vld(hdr_vld), .route(route), .from_sec(from_sec),
    .addr(addr), .dst_bus(dst_bus), .dst_dev(dst_dev), .dst_fn(dst_fn),
    .err_port(err_port), .err_fn(err_fn), .peer_claim(peer_claim),
    .io_base(io_base), .io_limit(io_limit), .mem_base(mem_base), .mem_limit(mem_limit),
    .pf_base(pf_base), .pf_limit(pf_limit), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .own_bus(own_bus), .own_dev(own_dev), .own_fn(own_fn),
    .claim(claim), .log_en(log_en), .unclaimed(unclaimed)
  );

  function automatic bit in_win(logic [63:0] a, logic [63:0] lo, logic [63:0] hi);
    return (hi >= lo) && (a >= lo) && (a <= hi);
  endfunction

  function automatic bit exp_claim();
    bit w;
    w = in_win(addr, {32'h0, io_base}, {32'h0, io_limit}) ||
        in_win(addr, {32'h0, mem_base}, {32'h0, mem_limit}) ||
        in_win(addr, pf_base, pf_limit);
    case (route)
      2'b00: return from_sec || w;
      2'b01: return from_sec || (dst_bus >= sec_bus && dst_bus <= sub_bus) ||
                    (dst_bus == own_bus && dst_dev == own_dev && dst_fn == own_fn);
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NF-1:0] owners(bit c);
    logic [NF-1:0] o;
    int p = 0;
    for (int i = 0; i < NF; i++) begin
      if (i == BIX) o[i] = c;
      else begin o[i] = peer_claim[p]; p++; end
    end
    return o;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // applies one header and checks the registered result and its hold
  task automatic apply(string req);
    bit c;
    logic [NF-1:0] o, le;
    bit orph;
    c = exp_claim();
    o = owners(c);
    le = err_port ? '1 : (err_fn ? o : '0);
    orph = err_fn && !err_port && (o == '0);
    hdr_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    hdr_vld = 1'b0;
    check({req, " claim"}, 64'(claim), 64'(c));
    check({req, " R8/R9 log_en"}, 64'(log_en), 64'(le));
    check({req, " R10 unclaimed"}, 64'(unclaimed), 64'(orph));
    route = ~route;
    from_sec = ~from_sec;
    @(posedge clk); @(negedge clk);
    check("R2 hold claim", 64'(claim), 64'(c));
    check("R2 hold log_en", 64'(log_en), 64'(le));
    check("R10 pulse ends", 64'(unclaimed), 64'd0);
  endtask

  task automatic hdr(logic [1:0] r, bit s, logic [63:0] a);
    route = r; from_sec = s; addr = a; err_port = 0; err_fn = 0; peer_claim = '0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset claim", 64'(claim), 64'd0);
    check("R1 reset log_en", 64'(log_en), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset claim", 64'(claim), 64'd0);
    check("R1 after reset unclaimed", 64'(unclaimed), 64'd0);

    // R3 window edges
    hdr(2'b00, 0, 64'h1000); apply("R3 io base");
    hdr(2'b00, 0, 64'h1FFF); apply("R3 io limit");
    hdr(2'b00, 0, 64'h2000); apply("R3 io above");
    hdr(2'b00, 0, 64'hFFF);  apply("R3 io below");
    hdr(2'b00, 0, 64'h80FF_FFFF); apply("R3 mem limit");
    hdr(2'b00, 0, 64'h8100_0000); apply("R3 mem above");
    hdr(2'b00, 0, 64'h0000_0001_0000_1000); apply("R3 upper bits miss io");
    hdr(2'b00, 0, 64'h0000_0004_0000_0000); apply("R3 pf base");
    hdr(2'b00, 0, 64'h0000_0005_0000_0000); apply("R3 pf above");
    // R4 reversed window
    io_base = 32'h3000; io_limit = 32'h2FFF;
    hdr(2'b00, 0, 64'h3000); apply("R4 reversed io");
    hdr(2'b00, 0, 64'h2FFF); apply("R4 reversed io limit");
    io_base = 32'h1000; io_limit = 32'h1FFF;
    // R5 ID routing
    hdr(2'b01, 0, 0); dst_bus = 8'd5; apply("R5 sec bus");
    hdr(2'b01, 0, 0); dst_bus = 8'd9; apply("R5 sub bus");
    hdr(2'b01, 0, 0); dst_bus = 8'd10; apply("R5 above sub");
    hdr(2'b01, 0, 0); dst_bus = 8'd2; dst_dev = 5'd3; dst_fn = 3'd0; apply("R5 own id");
    hdr(2'b01, 0, 0); dst_bus = 8'd2; dst_dev = 5'd3; dst_fn = 3'd1; apply("R5 own id miss");
    // R6 secondary side
    hdr(2'b00, 1, 64'hDEAD_0000_0000); apply("R6 sec addr");
    hdr(2'b01, 1, 0); dst_bus = 8'd200; apply("R6 sec id");
    // R7
    hdr(2'b10, 0, 0); apply("R7 implicit");
    hdr(2'b11, 1, 0); apply("R7 reserved");
    // R8, R9, R10
    hdr(2'b11, 0, 0); err_port = 1; err_fn = 1; apply("R8 port err");
    hdr(2'b00, 0, 64'h1500); err_fn = 1; apply("R9 own fn err");
    hdr(2'b11, 0, 0); err_fn = 1; peer_claim = 3'b010; apply("R9 peer fn err");
    hdr(2'b00, 0, 64'h50); err_fn = 1; apply("R10 orphan");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int pick;
      io_base = $urandom() & 32'hFFFF; io_limit = io_base + ($urandom() % 4096) - 256;
      mem_base = $urandom(); mem_limit = mem_base + ($urandom() % 65536) - 1024;
      pf_base = {28'h0, 4'($urandom()), $urandom()};
      pf_limit = pf_base + 64'($urandom() % 100000) - 64'd500;
      sec_bus = 8'($urandom()); sub_bus = sec_bus + 8'($urandom() % 8) - 8'd1;
      own_bus = 8'($urandom() % 4); own_dev = 5'($urandom() % 4); own_fn = 3'($urandom() % 2);
      route = 2'($urandom()); from_sec = ($urandom() % 4) == 0;
      pick = $urandom() % 6;
      case (pick)
        0: addr = {32'h0, io_base};
        1: addr = {32'h0, mem_limit};
        2: addr = pf_limit + 64'd1;
        3: addr = pf_base - 64'd1;
        4: addr = {32'h0, mem_base} - 64'd1;
        default: addr = {28'h0, 4'($urandom()), $urandom()};
      endcase
      dst_bus = ($urandom() % 2) ? sec_bus + 8'($urandom() % 9) - 8'd1 : 8'($urandom() % 4);
      dst_dev = 5'($urandom() % 4); dst_fn = 3'($urandom() % 2);
      err_port = ($urandom() % 5) == 0; err_fn = ($urandom() % 2) == 0;
      peer_claim = ($urandom() % 3 == 0) ? 3'(1 << ($urandom() % 3)) : 3'b0;
      apply("R3-R10 random");
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule